// File: doc/BRIEF.md
# UART Receive Data and Error Status

This block holds characters that a UART receiver has already deserialized and presents them to a CPU through two registers on a simple register bus. Each character is stored together with its own framing, parity and break indications. Storage is either a 16-entry queue or, when queueing is turned off, a single holding slot that acts as the first queue word. A configuration input selects between the two, and changing it empties the storage.

Software reads the data register first. That read removes the oldest character and copies its three error indications into the status register. It then reads the status register, which shows those indications plus a sticky overrun bit. The overrun bit is set when a character arrives while the storage is full; that character is dropped and the stored ones are kept. A write to the status address clears all four status bits together.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, a data read returns 0x00 and a status read returns 0x00.
- R2: With queueing on (`fifo_en_i`=1), data reads return the stored characters oldest first, and up to 16 characters are held; each read response appears on `bus_rdata_o` in the cycle after the read strobe.
- R3: The status register shows framing at bit 0, parity at bit 1 and break at bit 2. These bits take the values stored with a character only when a data read removes that character, and do not change when characters arrive.
- R4: Status bits 7 to 4 always read as 0.
- R5: A character that arrives while the storage is full sets status bit 3 (overrun) and is discarded; the characters already stored are returned unchanged.
- R6: The overrun bit stays set across data and status reads until a status write.
- R7: Any write to the status address (byte offset 0x4) clears status bits 0 to 3 together; a write to the data address (offset 0x0) has no effect.
- R8: A data read while the storage is empty returns the last character read, removes nothing, and leaves the status register unchanged.
- R9: With queueing off (`fifo_en_i`=0), the storage holds one character; a second character arriving before the first is read causes an overrun.
- R10: Changing `fifo_en_i` discards every stored character; characters received afterwards are stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | 1 selects the 16-entry queue, 0 the single holding slot; a change flushes storage |
| rx_valid_i | input | 1 | One-cycle strobe: a received character is offered |
| rx_data_i | input | 8 | Received character |
| rx_frame_err_i | input | 1 | Character had no valid stop bit |
| rx_parity_err_i | input | 1 | Character parity did not match the configured parity |
| rx_break_i | input | 1 | Line was held low longer than a full character frame |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Byte address: 0x0 data, 0x4 status |
| bus_rdata_o | output | 8 | Read response, valid the cycle after a read strobe |

## Verification
A character offered on `rx_valid_i` is captured at that clock edge, so a read strobe raised in the following cycle already sees it. Every read response is registered once and is due exactly one cycle after its strobe; the bench raises inputs on the falling edge and samples `bus_rdata_o` on the next falling edge, after that single register stage. A status read issued in the cycle right after a data read must already show the flags of the removed character, and the bench issues its status reads back to back with data reads to test that. Flushes from a mode change take effect at the first edge after `fifo_en_i` moves, so the bench waits two cycles before reading.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the UART receive status block.
// Assumes an 8-bit character and a four-bit status field.
package uart_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int FLAG_W = 4;

    // One stored character with its own error indications.
    typedef struct packed {
        logic              brk;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    // Status field; frm is bit 0, ovr is bit 3.
    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rx_flags_t;

endpackage

// File: rtl/uart_rx_decode.sv
// Module: register access decode.
// Turns a single-cycle bus strobe into one-hot read/write actions.
// Assumes at most one access per cycle; unknown addresses decode to nothing.
module uart_rx_decode #(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] DATA_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 4'h4
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_data_o,
    output logic              rd_stat_o,
    output logic              wr_stat_o
);

    logic hit_data;
    logic hit_stat;

    // Address match per register.
    always_comb begin
        hit_data = (addr_i == DATA_OFS);
        hit_stat = (addr_i == STAT_OFS);
    end

    // Qualify matches with strobe and direction; data writes go nowhere.
    always_comb begin
        rd_data_o = en_i && !we_i && hit_data;
        rd_stat_o = en_i && !we_i && hit_stat;
        wr_stat_o = en_i &&  we_i && hit_stat;
    end

endmodule

// File: rtl/uart_rx_store.sv
// Module: receive character storage.
// A circular queue of DEPTH entries whose usable capacity is DEPTH when
// queueing is enabled and one entry otherwise (the holding slot is simply
// the first queue word). Assumes DEPTH >= 2 and that flush_i is never
// combined with a push it wants kept.
module uart_rx_store #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fifo_en_i,
    input  logic                     flush_i,
    input  logic                     push_i,
    input  uart_rx_pkg::rx_char_t    push_char_i,
    input  logic                     pop_i,
    output uart_rx_pkg::rx_char_t    head_o,
    output logic                     empty_o,
    output logic                     full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    import uart_rx_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Capacity depends on the mode; the holding slot is one entry.
    always_comb begin
        empty_o = (count == '0);
        full_o  = fifo_en_i ? (count == CNT_MAX) : (count != '0);
        do_push = push_i && !full_o && !flush_i;
        do_pop  = pop_i && !empty_o && !flush_i;
        head_o  = mem[rd_ptr];
        count_o = count;
    end

    // Entry array write; contents need no reset as count guards them.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_char_i;
        end
    end

    // Pointer and occupancy bookkeeping, with flush emptying the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_flags.sv
// Module: status flag register.
// Framing, parity and break are replaced as a group when a character is
// removed by a data read; overrun is sticky. A clear strobe zeroes all
// four, but an overrun arriving in the same cycle still wins.
module uart_rx_flags (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  uart_rx_pkg::rx_char_t  load_char_i,
    input  logic                   ovr_set_i,
    input  logic                   clear_i,
    output uart_rx_pkg::rx_flags_t flags_o
);
    import uart_rx_pkg::*;

    rx_flags_t flags_q;

    // Per-character error bits: loaded on a pop, cleared on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            flags_q.frm <= 1'b0;
            flags_q.par <= 1'b0;
            flags_q.brk <= 1'b0;
        end else if (load_i) begin
            flags_q.frm <= load_char_i.frm;
            flags_q.par <= load_char_i.par;
            flags_q.brk <= load_char_i.brk;
        end
    end

    // Sticky overrun bit: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.ovr <= 1'b0;
        end else if (ovr_set_i) begin
            flags_q.ovr <= 1'b1;
        end else if (clear_i) begin
            flags_q.ovr <= 1'b0;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/uart_rx_status.sv
// Module: UART receive data and error status, top level.
// Stores received characters with their error bits, serves data and status
// reads with one cycle of latency, and tracks overrun. Assumes the receiver
// delivers at most one character per cycle and that accesses are single-cycle.
module uart_rx_status #(
    parameter int                DEPTH    = 16,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] DATA_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 4'h4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_en_i,
    input  logic                          rx_valid_i,
    input  logic [uart_rx_pkg::CHAR_W-1:0] rx_data_i,
    input  logic                          rx_frame_err_i,
    input  logic                          rx_parity_err_i,
    input  logic                          rx_break_i,
    input  logic                          bus_en_i,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    output logic [uart_rx_pkg::CHAR_W-1:0] bus_rdata_o
);
    import uart_rx_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PAD_W = CHAR_W - FLAG_W;

    logic              fifo_en_q;
    logic              flush;
    logic              rd_data;
    logic              rd_stat;
    logic              wr_stat;
    logic              push;
    logic              pop;
    logic              ovr_evt;
    logic              empty;
    logic              full;
    logic [CNT_W-1:0]  count;
    rx_char_t          in_char;
    rx_char_t          head;
    rx_flags_t         flags;
    logic [CHAR_W-1:0] last_data;
    logic [CHAR_W-1:0] rdata_q;

    // Remember the mode so that a change can be seen as a flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b1;
        end else begin
            fifo_en_q <= fifo_en_i;
        end
    end

    // Pack the incoming character and derive push, pop and overrun.
    always_comb begin
        flush          = (fifo_en_i != fifo_en_q);
        in_char.data   = rx_data_i;
        in_char.frm    = rx_frame_err_i;
        in_char.par    = rx_parity_err_i;
        in_char.brk    = rx_break_i;
        push           = rx_valid_i && !flush;
        ovr_evt        = push && full;
        pop            = rd_data && !empty;
    end

    uart_rx_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_OFS (DATA_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_decode (
        .en_i      (bus_en_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .rd_data_o (rd_data),
        .rd_stat_o (rd_stat),
        .wr_stat_o (wr_stat)
    );

    uart_rx_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en_i   (fifo_en_i),
        .flush_i     (flush),
        .push_i      (push),
        .push_char_i (in_char),
        .pop_i       (pop),
        .head_o      (head),
        .empty_o     (empty),
        .full_o      (full),
        .count_o     (count)
    );

    uart_rx_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (pop),
        .load_char_i (head),
        .ovr_set_i   (ovr_evt),
        .clear_i     (wr_stat),
        .flags_o     (flags)
    );

    // Last character handed to software, returned again on empty reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
        end else if (pop) begin
            last_data <= head.data;
        end
    end

    // Registered read response, updated only by read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_data) begin
            rdata_q <= empty ? last_data : head.data;
        end else if (rd_stat) begin
            rdata_q <= {PAD_W'(0), flags};
        end else if (bus_en_i && !bus_we_i) begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/uart_rx_status_chk.sv
// Module: property checker for uart_rx_status, attached with bind.
// Observes decode strobes, storage occupancy and the flag register.
module uart_rx_status_chk #(
    parameter int DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         fifo_en_i,
    input logic                         flush,
    input logic                         rx_valid_i,
    input logic                         full,
    input logic                         empty,
    input logic [$clog2(DEPTH+1)-1:0]   count,
    input logic                         rd_data,
    input logic                         rd_stat,
    input logic                         wr_stat,
    input uart_rx_pkg::rx_char_t        head,
    input uart_rx_pkg::rx_flags_t       flags,
    input logic [uart_rx_pkg::CHAR_W-1:0] last_data,
    input logic [uart_rx_pkg::CHAR_W-1:0] bus_rdata_o
);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !flush && full) |=> flags.ovr);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.ovr && !wr_stat) |=> flags.ovr);

    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !(rx_valid_i && !flush && full)) |=> (flags == '0));

    p_load_on_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !empty && !flush && !wr_stat) |=>
        ({flags.brk, flags.par, flags.frm} == $past({head.brk, head.par, head.frm})));

    p_pop_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !empty && !flush) |=> (bus_rdata_o == $past(head.data)));

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && empty) |=> ((bus_rdata_o == $past(last_data)) &&
                                $stable({flags.brk, flags.par, flags.frm})));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata_o[7:4] == 4'h0));

    p_hold_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && !flush) |-> (count <= 1));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

bind uart_rx_status uart_rx_status_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en_i   (fifo_en_i),
    .flush       (flush),
    .rx_valid_i  (rx_valid_i),
    .full        (full),
    .empty       (empty),
    .count       (count),
    .rd_data     (rd_data),
    .rd_stat     (rd_stat),
    .wr_stat     (wr_stat),
    .head        (head),
    .flags       (flags),
    .last_data   (last_data),
    .bus_rdata_o (bus_rdata_o)
);

// File: tb/uart_rx_status_tb.sv
// Bench for uart_rx_status: a vector table walked by one loop, then
// directed tests for reset, overrun, clearing, empty reads and modes.
module uart_rx_status_tb;

    localparam logic [3:0] A_DATA = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam int NVEC = 6;
    // {brk, par, frm, data}
    localparam logic [10:0] VEC [NVEC] = '{
        {3'b000, 8'h41}, {3'b001, 8'h5A}, {3'b010, 8'h00},
        {3'b100, 8'hC0}, {3'b011, 8'hFF}, {3'b101, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_frm = 1'b0;
    logic       rx_par = 1'b0;
    logic       rx_brk = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_status u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_en_i       (fifo_en),
        .rx_valid_i      (rx_valid),
        .rx_data_i       (rx_data),
        .rx_frame_err_i  (rx_frm),
        .rx_parity_err_i (rx_par),
        .rx_break_i      (rx_brk),
        .bus_en_i        (bus_en),
        .bus_we_i        (bus_we),
        .bus_addr_i      (bus_addr),
        .bus_rdata_o     (bus_rdata)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic push(logic [7:0] d, logic b, logic p, logic f);
        rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_par = p; rx_frm = f;
        @(negedge clk);
        rx_valid = 1'b0; rx_brk = 1'b0; rx_par = 1'b0; rx_frm = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wr(logic [3:0] a);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(A_STAT, v); check("R1 status after reset", v, 8'h00);
        rd(A_DATA, v); check("R1 data after reset", v, 8'h00);

        // Vector table: queue all, status must not move until reads (R3)
        for (int i = 0; i < NVEC; i++) push(VEC[i][7:0], VEC[i][10], VEC[i][9], VEC[i][8]);
        rd(A_STAT, v); check("R3 status unchanged by arrivals", v, 8'h00);
        for (int i = 0; i < NVEC; i++) begin
            rd(A_DATA, v); check("R2 queued order", v, VEC[i][7:0]);
            rd(A_STAT, v); check("R3 flags of read char", v, {5'b0, VEC[i][10:8]});
            check("R4 reserved bits zero", {4'b0, v[7:4]}, 8'h00);
        end

        // R8: empty read repeats last char, status untouched
        rd(A_DATA, v); check("R8 empty read data", v, 8'h7E);
        rd(A_STAT, v); check("R8 empty read status", v, 8'h05);

        // R7: data-address write ignored, status write clears
        wr(A_DATA);
        rd(A_STAT, v); check("R7 data write no effect", v, 8'h05);
        wr(A_STAT);
        rd(A_STAT, v); check("R7 status cleared", v, 8'h00);

        // R5: fill 16, then one more
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 1'b0, 1'b0, 1'b0);
        push(8'hEE, 1'b1, 1'b1, 1'b1);
        rd(A_STAT, v); check("R5 overrun set", v, 8'h08);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v); check("R5 contents kept", v, 8'h10 + 8'(i));
        end
        rd(A_STAT, v); check("R6 overrun sticky", v, 8'h08);
        rd(A_DATA, v); check("R5 extra char discarded", v, 8'h1F);
        rd(A_STAT, v); check("R6 overrun still set", v, 8'h08);
        wr(A_STAT);
        rd(A_STAT, v); check("R7 overrun cleared", v, 8'h00);

        // R9: holding mode, one slot
        fifo_en = 1'b0;
        repeat (2) @(negedge clk);
        push(8'hA1, 1'b0, 1'b1, 1'b0);
        push(8'hB2, 1'b0, 1'b0, 1'b0);
        rd(A_DATA, v); check("R9 holding keeps first", v, 8'hA1);
        rd(A_STAT, v); check("R9 holding overrun", v, 8'h0A);
        rd(A_DATA, v); check("R9 second char dropped", v, 8'hA1);
        wr(A_STAT);
        push(8'hC3, 1'b0, 1'b0, 1'b0);
        rd(A_DATA, v); check("R9 holding refill", v, 8'hC3);

        // R10: mode change flushes
        push(8'hD4, 1'b1, 1'b0, 1'b0);
        fifo_en = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_DATA, v); check("R10 flushed char gone", v, 8'hC3);
        rd(A_STAT, v); check("R10 status after flush", v, 8'h00);
        push(8'h55, 1'b0, 1'b0, 1'b1);
        push(8'h66, 1'b0, 1'b0, 1'b0);
        rd(A_DATA, v); check("R10 store after flush", v, 8'h55);
        rd(A_STAT, v); check("R10 flags after flush", v, 8'h01);
        rd(A_DATA, v); check("R10 second after flush", v, 8'h66);

        finish_run();
    end

endmodule